// File: doc/BRIEF.md
# Synchronous FIFO Threshold Offset Port

This block keeps the two programmable threshold values of a synchronous FIFO: the empty-side offset, which sets how close to empty the almost-empty flag fires, and the full-side offset, which does the same for almost-full. Both values feed the FIFO's flag logic continuously. Software or a host loads them through the FIFO's own write-side data bus and reads them back through the read-side data bus while an active-low load-select input is held low.

The write side runs on the write clock and the read side on the read clock. Each side keeps its own one-bit register pointer, which selects the empty offset first, then the full offset, then wraps back. A write with load select low steps the write pointer. A read with load select low steps the read pointer. The two pointers never affect each other. Read-back works only in standard mode. In first-word-fall-through mode the read side leaves its output and pointer alone. A write and a read issued on the same edge are reported on a collision output.

Top module: `ofs_prog_port`

## Requirements
- R1: While rst_ni is low, empty_ofs_o equals DEF_EMPTY, full_ofs_o equals DEF_FULL, data_o is zero and collide_o is low. Both pointers select the empty offset.
- R2: At a wclk_i rising edge with ld_ni low and wen_ni low, data_i[ADDR_W-1:0] is stored into the offset the write pointer selects, and the pointer then advances. The sequence is empty offset, full offset, empty offset, and so on.
- R3: At a wclk_i rising edge with ld_ni low and wen_ni high, neither offset changes and the write pointer stays where it is.
- R4: At a wclk_i rising edge with ld_ni high, neither offset changes and the write pointer stays, whatever wen_ni is.
- R5: At an rclk_i rising edge with ld_ni low, ren_ni low and fwft_i low, data_o takes the zero-extended offset the read pointer selects, and the read pointer advances in the same sequence as the write pointer.
- R6: The read pointer and the write pointer move independently. A write never moves the read pointer, and a read never moves the write pointer.
- R7: While fwft_i is high, a read request (ld_ni low, ren_ni low) leaves data_o and the read pointer unchanged.
- R8: data_i bits above ADDR_W-1 are ignored on a write, and data_o bits above ADDR_W-1 are always zero.
- R9: After a wclk_i rising edge with ld_ni, wen_ni and ren_ni all low, collide_o is high until the next wclk_i edge. After any other edge it is low.
- R10: At an rclk_i rising edge with ld_ni high or ren_ni high, data_o and the read pointer are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_ni | input | 1 | Load select, active low; routes the data ports to the offsets |
| wen_ni | input | 1 | Write enable, active low |
| ren_ni | input | 1 | Read enable, active low |
| fwft_i | input | 1 | High selects first-word-fall-through mode, which blocks read-back |
| data_i | input | DATA_W | Write-side data bus |
| data_o | output | DATA_W | Read-side data bus carrying offset read-back |
| empty_ofs_o | output | ADDR_W | Current empty-side offset, sent to the flag logic |
| full_ofs_o | output | ADDR_W | Current full-side offset, sent to the flag logic |
| collide_o | output | 1 | High for one write cycle after a simultaneous offset read and write |

## Verification
Directed sequences check the basic register behaviour. One sequence writes both offsets with the upper data bits set, which shows whether the bits are masked and whether the pointer wraps. Another issues reads after a single write, which shows whether the read pointer is tied to the write pointer. A read request in first-word-fall-through mode must not change data_o, which separates a blocked read from a plain hold. A read and a write issued together check the collision flag.

Random cycles then mix load select, both enables, the mode input and the data. These cycles reach pointer phases and back-to-back orderings that the directed cases skip. Each cycle is compared against a bench model of both pointers and both offsets.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;

  localparam int unsigned NUM_OFS = 2;

  function automatic ofs_sel_e next_sel(ofs_sel_e cur);
    return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction
endpackage

// File: rtl/ofs_wr_port.sv
module ofs_wr_port
  import ofs_pkg::*;
#(
  parameter int unsigned DATA_W    = 18,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DEF_EMPTY = 127,
  parameter int unsigned DEF_FULL  = 127
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] empty_o,
  output logic [ADDR_W-1:0] full_o
);
  ofs_sel_e          sel_q;
  logic [ADDR_W-1:0] ofs_q [NUM_OFS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= SEL_EMPTY;
    else if (we_i) sel_q <= next_sel(sel_q);
  end

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
    localparam logic [ADDR_W-1:0] RST_V =
      (g == int'(SEL_EMPTY)) ? ADDR_W'(DEF_EMPTY) : ADDR_W'(DEF_FULL);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           ofs_q[g] <= RST_V;
      else if (we_i && (sel_q == 1'(g)))    ofs_q[g] <= data_i[ADDR_W-1:0];
    end
  end

  assign empty_o = ofs_q[SEL_EMPTY];
  assign full_o  = ofs_q[SEL_FULL];
endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
  import ofs_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] empty_i,
  input  logic [ADDR_W-1:0] full_i,
  output logic [DATA_W-1:0] data_o
);
  ofs_sel_e          sel_q;
  logic [ADDR_W-1:0] pick;

  assign pick = (sel_q == SEL_FULL) ? full_i : empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= SEL_EMPTY;
      data_o <= '0;
    end else if (re_i) begin
      sel_q  <= next_sel(sel_q);
      data_o <= DATA_W'(pick);  // zero-extend
    end
  end
endmodule

// File: rtl/ofs_prog_port.sv
module ofs_prog_port #(
  parameter int unsigned DATA_W    = 18,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DEF_EMPTY = 127,
  parameter int unsigned DEF_FULL  = 127
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              ld_ni,
  input  logic              wen_ni,
  input  logic              ren_ni,
  input  logic              fwft_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [ADDR_W-1:0] empty_ofs_o,
  output logic [ADDR_W-1:0] full_ofs_o,
  output logic              collide_o
);
  logic we, re, rd_req;

  assign we     = !ld_ni && !wen_ni;
  assign rd_req = !ld_ni && !ren_ni;
  assign re     = rd_req && !fwft_i;  // read-back only in standard mode

  ofs_wr_port #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .DEF_EMPTY(DEF_EMPTY), .DEF_FULL(DEF_FULL)
  ) u_wr (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .data_i (data_i),
    .empty_o(empty_ofs_o),
    .full_o (full_ofs_o)
  );

  ofs_rd_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .re_i   (re),
    .empty_i(empty_ofs_o),
    .full_i (full_ofs_o),
    .data_o (data_o)
  );

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) collide_o <= 1'b0;
    else         collide_o <= we && rd_req;
  end
endmodule

// File: rtl/ofs_prog_chk.sv
module ofs_prog_chk #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 8
) (
  input logic              wclk_i,
  input logic              rclk_i,
  input logic              rst_ni,
  input logic              ld_ni,
  input logic              wen_ni,
  input logic              ren_ni,
  input logic              fwft_i,
  input logic [DATA_W-1:0] data_o,
  input logic [ADDR_W-1:0] empty_ofs_o,
  input logic [ADDR_W-1:0] full_ofs_o,
  input logic              collide_o
);
  a_r2_one_ofs_per_write: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!ld_ni && !wen_ni) |=> ($stable(empty_ofs_o) || $stable(full_ofs_o)));

  a_r3_wen_high_hold: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!ld_ni && wen_ni) |=> ($stable(empty_ofs_o) && $stable(full_ofs_o)));

  a_r4_ld_high_hold: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ld_ni |=> ($stable(empty_ofs_o) && $stable(full_ofs_o)));

  a_r7_fwft_blocks_read: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    fwft_i |=> $stable(data_o));

  a_r10_idle_read_hold: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (ld_ni || ren_ni) |=> $stable(data_o));

  a_r8_upper_zero: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    data_o[DATA_W-1:ADDR_W] == '0);

  a_r9_collide_set: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!ld_ni && !wen_ni && !ren_ni) |=> collide_o);

  a_r9_collide_clr: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !(!ld_ni && !wen_ni && !ren_ni) |=> !collide_o);
endmodule

bind ofs_prog_port ofs_prog_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .ld_ni(ld_ni),
  .wen_ni(wen_ni), .ren_ni(ren_ni), .fwft_i(fwft_i), .data_o(data_o),
  .empty_ofs_o(empty_ofs_o), .full_ofs_o(full_ofs_o), .collide_o(collide_o)
);

// File: tb/sim_ofs_prog_port.sv
`timescale 1ns/1ps
module sim_ofs_prog_port;
  localparam int DATA_W = 18;
  localparam int ADDR_W = 8;
  localparam int DEF_E  = 127;
  localparam int DEF_F  = 127;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_n = 1'b1, wen_n = 1'b1, ren_n = 1'b1, fwft = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic [ADDR_W-1:0] e_ofs, f_ofs;
  logic collide;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // bench model
  logic [ADDR_W-1:0] m_e, m_f;
  bit m_wp, m_rp;
  logic [DATA_W-1:0] m_dout;
  bit m_col;

  always #10 clk = ~clk;  // 50 MHz

  ofs_prog_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
                  .DEF_EMPTY(DEF_E), .DEF_FULL(DEF_F)) u0 (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n), .ld_ni(ld_n),
    .wen_ni(wen_n), .ren_ni(ren_n), .fwft_i(fwft), .data_i(din),
    .data_o(dout), .empty_ofs_o(e_ofs), .full_ofs_o(f_ofs),
    .collide_o(collide)
  );

  function automatic logic [DATA_W-1:0] zext(logic [ADDR_W-1:0] v);
    return DATA_W'(v);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_e = ADDR_W'(DEF_E); m_f = ADDR_W'(DEF_F);
    m_wp = 0; m_rp = 0; m_dout = '0; m_col = 0;
  endtask

  // called at a negedge; drives, clocks, updates model, checks at next negedge
  task automatic step(bit ld, bit wen, bit ren, bit fw, logic [DATA_W-1:0] d);
    string wtag, rtag;
    ld_n = ld; wen_n = wen; ren_n = ren; fwft = fw; din = d;
    @(posedge clk);
    if (!ld && !ren && !fw) begin
      m_dout = zext(m_rp ? m_f : m_e);
      m_rp = !m_rp;
    end
    m_col = !ld && !wen && !ren;
    if (!ld && !wen) begin
      if (m_wp) m_f = d[ADDR_W-1:0]; else m_e = d[ADDR_W-1:0];
      m_wp = !m_wp;
    end
    @(negedge clk);
    wtag = ld ? "R4" : (wen ? "R3" : "R2");
    rtag = (ld || ren) ? "R10" : (fw ? "R7" : "R5");
    chk({wtag, " empty"}, 32'(e_ofs), 32'(m_e));
    chk({wtag, " full"},  32'(f_ofs), 32'(m_f));
    chk(rtag, 32'(dout), 32'(m_dout));
    chk("R8 upper", 32'(dout >> ADDR_W), 0);
    chk("R9", 32'(collide), 32'(m_col));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0a11);
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 empty", 32'(e_ofs), DEF_E);
    chk("R1 full", 32'(f_ofs), DEF_F);
    chk("R1 dout", 32'(dout), 0);
    chk("R1 collide", 32'(collide), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R8: write both offsets with upper bits set, then wrap
    step(0, 0, 1, 0, 18'h3FF12);
    step(0, 0, 1, 0, 18'h2AB34);
    chk("R8 masked", 32'(e_ofs), 32'h12);
    step(0, 0, 1, 0, 18'h00056);
    chk("R2 wrap", 32'(e_ofs), 32'h56);
    // R3/R4: ignored writes
    step(0, 1, 1, 0, 18'h000AA);
    step(1, 0, 1, 0, 18'h000BB);
    // R6: write pointer now at full; reads start at empty
    step(0, 1, 0, 0, '0);
    chk("R6 rd empty first", 32'(dout), 32'h56);
    step(0, 1, 0, 0, '0);
    chk("R6 rd full next", 32'(dout), 32'h34);
    // R7: fwft blocks read
    step(0, 1, 0, 1, '0);
    chk("R7 hold", 32'(dout), 32'h34);
    // R9: collision
    step(0, 0, 0, 0, 18'h00077);
    chk("R9 set", 32'(collide), 1);
    step(1, 1, 1, 0, '0);
    chk("R9 clear", 32'(collide), 0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      bit ld, wen, ren, fw;
      ld  = ($urandom_range(3) == 0);
      wen = $urandom_range(1);
      ren = $urandom_range(1);
      fw  = ($urandom_range(4) == 0);
      step(ld, wen, ren, fw, DATA_W'($urandom));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule